// File: doc/BRIEF.md
# Compressed Trace Message Generator

This block watches a processor's instruction-retirement stream and its load/store stream and turns them into a compact series of trace messages for an external debugger. A retired instruction that changes the flow of control (a taken branch or an exception entry) yields a flow message carrying its target address. Straight-line instructions yield nothing, because the host can rebuild them from its copy of the code. A load or store yields a data message only when its address lies inside a programmed window and its direction is one of the enabled kinds. A software write of a task number to a dedicated register yields a task-switch message carrying that number.

Messages wait in a small FIFO and leave through a valid/ready interface toward the port serializer. When the FIFO has no room, messages are dropped and one loss marker is queued as soon as space returns. Tracing can be held off until an external watchpoint trigger arrives. Clearing the global enable stops all tracing and forgets any earlier trigger.

Top module: `trace_msg_gen`

## Requirements
- R1: After reset, `msg_valid` is 0 until a message has been queued.
- R2: A retired instruction with `ret_flow`=1 queues one message of kind 0 whose field is `ret_target`, with data 0 and write bit 0. A retired instruction with `ret_flow`=0 queues nothing.
- R3: An access with `win_lo` <= `mem_addr` <= `win_hi` (unsigned, both ends inclusive) that passes the direction filter queues one message of kind 1. Its field is the address, its data is `mem_data`, and its write bit is `mem_write` (1 = store). An access outside the window queues nothing.
- R4: Stores pass the direction filter only when `sel_wr`=1, and loads pass it only when `sel_rd`=1.
- R5: A pulse on `task_wr` queues one message of kind 2 whose field is `task_id`, with data 0.
- R6: Messages that arise in the same cycle are queued in the order task, flow, data. Messages in each stream keep the order of their inputs.
- R7: A message that finds no free FIFO entry, counted before the same cycle's read, is dropped. After one or more drops, exactly one message of kind 3, with field 0 and data 0, is queued ahead of all others in the first cycle that has a free entry.
- R8: With `wait_trig`=1, no message from any stream is queued until the cycle after `trig_in` is seen high while `trace_en`=1.
- R9: While `trace_en`=0 no stream message is queued. Lowering `trace_en` also forgets a trigger that was seen earlier.
- R10: While `msg_valid`=1 and `msg_ready`=0, all outputs of the message port hold their values. Messages leave in the order they were queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Global trace enable |
| wait_trig | input | 1 | Hold off tracing until a trigger |
| trig_in | input | 1 | Watchpoint trigger |
| sel_rd | input | 1 | Trace loads in the window |
| sel_wr | input | 1 | Trace stores in the window |
| win_lo | input | 32 | Lowest traced address |
| win_hi | input | 32 | Highest traced address |
| ret_valid | input | 1 | Instruction retired this cycle |
| ret_flow | input | 1 | Retired instruction was a taken branch or exception |
| ret_target | input | 32 | Target address of the flow change |
| mem_valid | input | 1 | Memory access this cycle |
| mem_write | input | 1 | Access is a store |
| mem_addr | input | 32 | Access address |
| mem_data | input | 32 | Access data |
| task_wr | input | 1 | Software write to the task register |
| task_id | input | 32 | Task number written |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Serializer takes the message |
| msg_kind | output | 2 | 0 flow, 1 data, 2 task, 3 loss |
| msg_field | output | 32 | Address or task number |
| msg_data | output | 32 | Access data (data messages) |
| msg_wr | output | 1 | Store flag (data messages) |

## Verification
Flow tracing is driven with a mix of flow and sequential retirements, which shows whether compression drops exactly the straight-line ones. Data tracing uses addresses at the window edges and one step outside them, under each direction setting, which shows off-by-one and filter-polarity faults. Bursts where all three sources fire together, and long stalls of `msg_ready`, check the queue order and the single loss marker. Traffic before and after a trigger, and around a toggle of the enable, checks the arming logic. A behavioural queue model in the bench is compared with the message port after every clock.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    K_FLOW = 2'd0,
    K_DATA = 2'd1,
    K_TASK = 2'd2,
    K_LOST = 2'd3
  } msg_kind_e;

  typedef struct packed {
    msg_kind_e          kind;
    logic [ADDR_W-1:0]  field;
    logic [DATA_W-1:0]  data;
    logic               wr;
  } msg_t;

  // candidate slots in queue priority order
  localparam int N_SRC  = 4;
  localparam int S_LOST = 0;
  localparam int S_TASK = 1;
  localparam int S_FLOW = 2;
  localparam int S_DATA = 3;
endpackage

// File: rtl/trace_gate.sv
module trace_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic trace_en,
  input  logic wait_trig,
  input  logic trig_in,
  output logic active
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (!trace_en)    armed_d = 1'b0;
    else if (trig_in) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign active = trace_en & (~wait_trig | armed_q);
endmodule

// File: rtl/trace_source.sv
module trace_source
  import trace_pkg::*;
(
  input  logic              active,
  input  logic              sel_rd,
  input  logic              sel_wr,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  input  logic              ret_valid,
  input  logic              ret_flow,
  input  logic [ADDR_W-1:0] ret_target,
  input  logic              mem_valid,
  input  logic              mem_write,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              task_wr,
  input  logic [ADDR_W-1:0] task_id,
  output logic              task_v,
  output msg_t              task_m,
  output logic              flow_v,
  output msg_t              flow_m,
  output logic              data_v,
  output msg_t              data_m
);
  logic in_win, dir_ok;

  assign in_win = (mem_addr >= win_lo) && (mem_addr <= win_hi);
  assign dir_ok = mem_write ? sel_wr : sel_rd;

  always_comb begin
    task_v = active & task_wr;
    task_m = '{kind: K_TASK, field: task_id, data: '0, wr: 1'b0};

    flow_v = active & ret_valid & ret_flow;
    flow_m = '{kind: K_FLOW, field: ret_target, data: '0, wr: 1'b0};

    data_v = active & mem_valid & in_win & dir_ok;
    data_m = '{kind: K_DATA, field: mem_addr, data: mem_data, wr: mem_write};
  end
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo
  import trace_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NWR   = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NWR-1:0] wr_en,   // packed from bit 0 upward
  input  msg_t          wr_msg [NWR],
  input  logic          rd_en,
  output msg_t          rd_msg,
  output logic          not_empty,
  output logic [CW-1:0] fill
);
  msg_t          mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] n_wr;
  logic          pop;

  assign not_empty = (cnt_q != '0);
  assign pop       = rd_en & not_empty;
  assign rd_msg    = mem[rptr_q];
  assign fill      = cnt_q;

  always_comb begin
    n_wr = '0;
    for (int i = 0; i < NWR; i++) n_wr = n_wr + CW'(wr_en[i]);
    wptr_d = wptr_q + PW'(n_wr);
    rptr_d = rptr_q + PW'(pop);
    cnt_d  = cnt_q + n_wr - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  generate
    for (genvar g = 0; g < NWR; g++) begin : g_wr
      always_ff @(posedge clk) begin
        if (wr_en[g]) mem[wptr_q + PW'(g)] <= wr_msg[g];
      end
    end
  endgenerate
endmodule

// File: rtl/trace_msg_gen.sv
module trace_msg_gen
  import trace_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trace_en,
  input  logic        wait_trig,
  input  logic        trig_in,
  input  logic        sel_rd,
  input  logic        sel_wr,
  input  logic [31:0] win_lo,
  input  logic [31:0] win_hi,
  input  logic        ret_valid,
  input  logic        ret_flow,
  input  logic [31:0] ret_target,
  input  logic        mem_valid,
  input  logic        mem_write,
  input  logic [31:0] mem_addr,
  input  logic [31:0] mem_data,
  input  logic        task_wr,
  input  logic [31:0] task_id,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [1:0]  msg_kind,
  output logic [31:0] msg_field,
  output logic [31:0] msg_data,
  output logic        msg_wr
);
  logic          active;
  logic          task_v, flow_v, data_v;
  msg_t          task_m, flow_m, data_m;
  logic [N_SRC-1:0] cand_v;
  msg_t          cand_m [N_SRC];
  logic [N_SRC-1:0] slot_en;
  msg_t          slot_m [N_SRC];
  logic          any_drop, lost_taken;
  logic          lost_q, lost_d;
  logic [CW-1:0] fill;
  msg_t          head;

  trace_gate u_gate (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en),
    .wait_trig(wait_trig), .trig_in(trig_in), .active(active)
  );

  trace_source u_src (
    .active(active), .sel_rd(sel_rd), .sel_wr(sel_wr),
    .win_lo(win_lo), .win_hi(win_hi),
    .ret_valid(ret_valid), .ret_flow(ret_flow), .ret_target(ret_target),
    .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_data(mem_data),
    .task_wr(task_wr), .task_id(task_id),
    .task_v(task_v), .task_m(task_m),
    .flow_v(flow_v), .flow_m(flow_m),
    .data_v(data_v), .data_m(data_m)
  );

  always_comb begin
    cand_v[S_LOST] = lost_q;
    cand_m[S_LOST] = '{kind: K_LOST, field: '0, data: '0, wr: 1'b0};
    cand_v[S_TASK] = task_v;
    cand_m[S_TASK] = task_m;
    cand_v[S_FLOW] = flow_v;
    cand_m[S_FLOW] = flow_m;
    cand_v[S_DATA] = data_v;
    cand_m[S_DATA] = data_m;
  end

  // pack accepted candidates into consecutive write slots
  always_comb begin
    int k;
    int room;
    k        = 0;
    room     = DEPTH - int'(fill);
    any_drop = 1'b0;
    lost_taken = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      slot_en[i] = 1'b0;
      slot_m[i]  = '0;
    end
    for (int i = 0; i < N_SRC; i++) begin
      if (cand_v[i]) begin
        if (k < room) begin
          slot_en[k] = 1'b1;
          slot_m[k]  = cand_m[i];
          k = k + 1;
          if (i == S_LOST) lost_taken = 1'b1;
        end else if (i != S_LOST) begin
          any_drop = 1'b1;
        end
      end
    end
    lost_d = (lost_q & ~lost_taken) | any_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lost_q <= 1'b0;
    else        lost_q <= lost_d;
  end

  trace_fifo #(.DEPTH(DEPTH), .NWR(N_SRC)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(slot_en), .wr_msg(slot_m),
    .rd_en(msg_ready), .rd_msg(head),
    .not_empty(msg_valid), .fill(fill)
  );

  assign msg_kind  = head.kind;
  assign msg_field = head.field;
  assign msg_data  = head.data;
  assign msg_wr    = head.wr;
endmodule

// File: rtl/trace_msg_gen_chk.sv
module trace_msg_gen_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trace_en,
  input logic          lost_q,
  input logic [CW-1:0] fill,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [1:0]    msg_kind,
  input logic [31:0]   msg_field,
  input logic [31:0]   msg_data,
  input logic          msg_wr
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !msg_valid);

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) &&
      $stable(msg_field) && $stable(msg_data) && $stable(msg_wr)));

  a_r7_loss_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == 2'd3) |-> (msg_field == '0 && msg_data == '0));

  a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!trace_en && !lost_q && !msg_valid) |=> !msg_valid);
endmodule

bind trace_msg_gen trace_msg_gen_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .lost_q(lost_q),
  .fill(fill), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_kind(msg_kind), .msg_field(msg_field), .msg_data(msg_data),
  .msg_wr(msg_wr)
);

// File: tb/test_trace_msg_gen.sv
module test_trace_msg_gen;
  localparam int DEPTH = 8;
  localparam logic [31:0] LO = 32'h0000_1000;
  localparam logic [31:0] HI = 32'h0000_1FFC;

  logic clk = 1'b0;
  logic rst_n;
  logic trace_en, wait_trig, trig_in, sel_rd, sel_wr;
  logic [31:0] win_lo, win_hi;
  logic ret_valid, ret_flow;
  logic [31:0] ret_target;
  logic mem_valid, mem_write;
  logic [31:0] mem_addr, mem_data;
  logic task_wr;
  logic [31:0] task_id;
  logic msg_valid, msg_ready;
  logic [1:0] msg_kind;
  logic [31:0] msg_field, msg_data;
  logic msg_wr;

  always #5 clk = ~clk;

  trace_msg_gen #(.DEPTH(DEPTH)) i_trace_msg_gen (.*);

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // model state
  logic [66:0] q[$];
  bit armed_m = 0;
  bit lost_m  = 0;

  task automatic model_step();
    int room;
    int k;
    bit act, drop;
    logic [66:0] c[$];
    room = DEPTH - q.size();
    if (q.size() > 0 && msg_ready) void'(q.pop_front());
    act = trace_en && (!wait_trig || armed_m);
    if (!trace_en) armed_m = 0; else if (trig_in) armed_m = 1;
    k = 0; drop = 0;
    if (lost_m) begin
      if (room > 0) begin q.push_back({2'd3, 32'd0, 32'd0, 1'b0}); k++; lost_m = 0; end
    end
    if (act && task_wr) c.push_back({2'd2, task_id, 32'd0, 1'b0});
    if (act && ret_valid && ret_flow) c.push_back({2'd0, ret_target, 32'd0, 1'b0});
    if (act && mem_valid && mem_addr >= win_lo && mem_addr <= win_hi &&
        (mem_write ? sel_wr : sel_rd))
      c.push_back({2'd1, mem_addr, mem_data, mem_write});
    foreach (c[i]) begin
      if (k < room) begin q.push_back(c[i]); k++; end
      else drop = 1;
    end
    if (drop) lost_m = 1;
  endtask

  task automatic compare();
    bit exp_v;
    logic [66:0] got, exp;
    exp_v = (q.size() > 0);
    checks++;
    if (msg_valid !== exp_v) begin
      errors++;
      $display("FAIL %s: msg_valid actual=%0b expected=%0b", cur_req, msg_valid, exp_v);
    end else if (exp_v) begin
      got = {msg_kind, msg_field, msg_data, msg_wr};
      exp = q[0];
      if (got !== exp) begin
        errors++;
        $display("FAIL %s: message actual=%h expected=%h", cur_req, got, exp);
      end
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle_inputs();
    ret_valid = 0; ret_flow = 0; mem_valid = 0; task_wr = 0; trig_in = 0;
  endtask

  function automatic logic [31:0] pick_addr();
    case ($urandom_range(0, 5))
      0: return LO - 1;
      1: return LO;
      2: return HI;
      3: return HI + 1;
      4: return LO + ($urandom_range(1, 1000) * 4);
      default: return $urandom();
    endcase
  endfunction

  task automatic drive(int pf, int pm, int po, int pr);
    ret_valid  = ($urandom_range(0, 99) < pf);
    ret_flow   = $urandom_range(0, 1);
    ret_target = $urandom();
    mem_valid  = ($urandom_range(0, 99) < pm);
    mem_write  = $urandom_range(0, 1);
    mem_addr   = pick_addr();
    mem_data   = $urandom();
    task_wr    = ($urandom_range(0, 99) < po);
    task_id    = $urandom();
    msg_ready  = ($urandom_range(0, 99) < pr);
    tick();
  endtask

  task automatic drain();
    idle_inputs(); msg_ready = 1;
    for (int i = 0; i < DEPTH + 4; i++) tick();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not finish actual=timeout expected=end");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 0; trace_en = 0; wait_trig = 0; sel_rd = 1; sel_wr = 1;
    win_lo = LO; win_hi = HI; msg_ready = 0;
    ret_target = 0; mem_write = 0; mem_addr = 0; mem_data = 0; task_id = 0;
    idle_inputs();
    repeat (4) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; compare();
    tick(); tick();

    trace_en = 1;
    cur_req = "R2";
    for (int i = 0; i < 200; i++) drive(80, 0, 0, 100);
    drain();

    cur_req = "R3";
    for (int i = 0; i < 300; i++) drive(0, 90, 0, 100);
    drain();

    cur_req = "R4";
    sel_rd = 1; sel_wr = 0;
    for (int i = 0; i < 150; i++) drive(0, 90, 0, 100);
    sel_rd = 0; sel_wr = 1;
    for (int i = 0; i < 150; i++) drive(0, 90, 0, 100);
    sel_rd = 0; sel_wr = 0;
    for (int i = 0; i < 50; i++) drive(0, 90, 0, 100);
    sel_rd = 1; sel_wr = 1;
    drain();

    cur_req = "R5";
    for (int i = 0; i < 100; i++) drive(0, 0, 60, 100);
    drain();

    cur_req = "R6";
    for (int i = 0; i < 200; i++) drive(100, 100, 100, 100);
    drain();

    cur_req = "R7";
    for (int j = 0; j < 6; j++) begin
      for (int i = 0; i < 12; i++) drive(70, 70, 40, 0);
      for (int i = 0; i < 20; i++) drive(30, 30, 10, 100);
    end
    drain();

    cur_req = "R8";
    wait_trig = 1;
    for (int i = 0; i < 60; i++) drive(70, 70, 30, 100);
    trig_in = 1; ret_valid = 1; ret_flow = 1; ret_target = 32'hABCD_0000;
    msg_ready = 1; tick();
    trig_in = 0;
    for (int i = 0; i < 60; i++) drive(70, 70, 30, 100);
    drain();

    cur_req = "R9";
    trace_en = 0;
    for (int i = 0; i < 40; i++) drive(80, 80, 40, 100);
    trace_en = 1;
    for (int i = 0; i < 40; i++) drive(80, 80, 40, 100);
    trig_in = 1; tick(); trig_in = 0;
    for (int i = 0; i < 40; i++) drive(80, 80, 40, 100);
    wait_trig = 0;
    trace_en = 0;
    for (int i = 0; i < 20; i++) drive(80, 80, 40, 100);
    trace_en = 1;
    drain();

    cur_req = "R10";
    for (int i = 0; i < 1500; i++) drive(50, 50, 15, 40);
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule